// File: doc/BRIEF.md
# Command Descriptor List Sequencer

This block is the control unit of a command-driven peripheral. Software leaves a command word in a small shared control area in memory and pulses channel attention. The sequencer then reads and clears that word, acknowledges status flags, and moves the command unit and receive unit between their states. When the command unit is active, it walks a linked chain of command descriptors. For each descriptor it marks the entry busy, hands the opcode to an external executor, marks the entry complete, and follows the link. After every descriptor it rewrites the status word in the control area.

All memory traffic goes through a single 16-bit word port with a 32-bit byte address. A request on this port is held until it is granted. Executors for the individual opcodes live outside the block. They receive the opcode and the descriptor address and answer with a done strobe. Attention pulses that arrive while a pass is in progress are counted, and each one is served later by a further pass.

Top module: `cmd_chain_seq`

## Requirements
- R1: After reset there is no memory request, no executor dispatch and no interrupt until channel attention arrives. At reset the command unit is idle (code 0), the receive unit is suspended (code 1), all flags are clear and the list pointer is null (all ones).
- R2: Each pass first reads the word at control base + 2 and then writes 0x0000 to that address.
- R3: Bits 15:12 of the command word acknowledge status flags. Each set bit clears the flag at the same position of the status word.
- R4: Command-unit field (command bits 10:8): 1 sets the unit active (code 2); 4 sets it suspended (code 1) and sets flag bit 13. Receive-unit field (bits 6:4): 1 or 2 sets it idle (code 0); 3 or 4 sets it suspended (code 1) and sets flag bit 12. Other field values leave the unit unchanged.
- R5: Command bit 7 is applied after the fields. It clears all flags, sets the command unit idle, sets the receive unit suspended and nulls the list pointer.
- R6: After the command word is handled, the list pointer is reloaded in one case only: the command unit is not suspended and the pointer is null. The reload reads the low half from base + 4 and the high half from base + 6. The pass then writes the status word to base + 0. The status word holds the flags in bits 15:12, the command-unit code in bits 9:8 and the receive-unit code in bits 6:4; all other bits are zero.
- R7: Descriptors are processed only while the command unit is active and the pointer is not null. For each descriptor the block:
  - writes 0x4000 to the descriptor address;
  - reads the word at + 2;
  - presents bits 2:0 of that word as the opcode, together with the descriptor address, and waits for done;
  - writes 0xA000 to the descriptor address;
  - reads the link, low half at + 4 and high half at + 6.
- R8: A zero link, or descriptor bit 15, makes the pointer null. Descriptor bit 14 suspends the command unit. After each descriptor the status word is written to base + 0, and the walk continues only while the unit is active and the pointer is not null.
- R9: Descriptor bit 13 sets status flag bit 15 and raises the interrupt output for exactly the status write that follows that descriptor. When bit 13 is clear, flag bit 15 is cleared and no interrupt is raised.
- R10: Channel attention that arrives during a pass is counted. Each counted pulse later triggers one more complete pass.
- R11: A memory request holds its address, direction and write data unchanged until it is granted. An executor dispatch holds until done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ca | input | 1 | Channel attention pulse |
| ctrl_base | input | 32 | Byte address of the shared control area |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 16 | Write data |
| mem_gnt | input | 1 | Grant; completes the request in this cycle |
| mem_rdata | input | 16 | Read data, valid with grant |
| cmd_valid | output | 1 | Descriptor dispatched to executor |
| cmd_opcode | output | 3 | Descriptor opcode |
| cmd_addr | output | 32 | Descriptor address |
| cmd_done | input | 1 | Executor finished |
| irq | output | 1 | Interrupt, high during the status write after an interrupting descriptor |

## Verification
Every wrong internal state in this block ends up on the memory port. A wrong unit code or flag appears in the next status write to base + 0. A wrong pointer shows up as a wrong address in the very next descriptor access. A lost or extra attention pulse shows up as a missing or surplus pass that reads base + 2. The bench therefore models the memory sequence behaviourally and compares every granted transaction, every dispatch and the interrupt level on every clock. Any divergence is reported within the transaction in which it first becomes visible.

// File: rtl/seq_pkg.sv
package seq_pkg;

    localparam int AW = 32;
    localparam int DW = 16;

    localparam logic [AW-1:0] PTR_NULL = '1;

    // byte offsets inside the control area
    localparam logic [AW-1:0] CB_STATUS  = 32'd0;
    localparam logic [AW-1:0] CB_COMMAND = 32'd2;
    localparam logic [AW-1:0] CB_LIST_LO = 32'd4;
    localparam logic [AW-1:0] CB_LIST_HI = 32'd6;

    // byte offsets inside a descriptor
    localparam logic [AW-1:0] DS_STATUS  = 32'd0;
    localparam logic [AW-1:0] DS_CMD     = 32'd2;
    localparam logic [AW-1:0] DS_LINK_LO = 32'd4;
    localparam logic [AW-1:0] DS_LINK_HI = 32'd6;

    localparam logic [DW-1:0] WORD_BUSY = 16'h4000;
    localparam logic [DW-1:0] WORD_DONE = 16'hA000;

    typedef enum logic [1:0] {
        CU_IDLE = 2'd0,
        CU_SUSP = 2'd1,
        CU_ACT  = 2'd2
    } cu_e;

    typedef enum logic [2:0] {
        RU_IDLE  = 3'd0,
        RU_SUSP  = 3'd1,
        RU_READY = 3'd4
    } ru_e;

    // flags[3]=status bit15, [2]=bit14, [1]=bit13, [0]=bit12
    typedef struct packed {
        logic [3:0] flags;
        cu_e        cu;
        ru_e        ru;
    } unit_t;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CW_RD,
        S_CW_CLR,
        S_BASE_LO,
        S_BASE_HI,
        S_HDR_WR,
        S_D_BUSY,
        S_D_CMD,
        S_D_EXEC,
        S_D_DONE,
        S_D_LNK_LO,
        S_D_LNK_HI
    } seq_st_e;

    function automatic unit_t cw_apply(unit_t u, logic [DW-1:0] cw);
        unit_t n;
        n = u;
        n.flags = u.flags & ~cw[15:12];
        case (cw[10:8])
            3'd1: n.cu = CU_ACT;
            3'd4: begin
                n.cu       = CU_SUSP;
                n.flags[1] = 1'b1;
            end
            default: ;
        endcase
        case (cw[6:4])
            3'd1, 3'd2: n.ru = RU_IDLE;
            3'd3, 3'd4: begin
                n.ru       = RU_SUSP;
                n.flags[0] = 1'b1;
            end
            default: ;
        endcase
        if (cw[7]) begin
            n.flags = '0;
            n.cu    = CU_IDLE;
            n.ru    = RU_SUSP;
        end
        return n;
    endfunction

    function automatic unit_t desc_apply(unit_t u, logic [DW-1:0] dw);
        unit_t n;
        n = u;
        if (dw[14]) n.cu = CU_SUSP;
        n.flags[3] = dw[13];
        return n;
    endfunction

    function automatic logic [DW-1:0] status_word(unit_t u);
        return {u.flags, 2'b00, u.cu, 1'b0, u.ru, 4'b0000};
    endfunction

endpackage

// File: rtl/seq_unit_state.sv
module seq_unit_state
    import seq_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          apply_cw,
    input  logic [DW-1:0] cw,
    input  logic          apply_desc,
    input  logic [DW-1:0] dw,
    output unit_t         unit
);

    always_ff @(posedge clk) begin
        if (rst) begin
            unit <= '{flags: 4'b0000, cu: CU_IDLE, ru: RU_SUSP};
        end else if (apply_cw) begin
            unit <= cw_apply(unit, cw);
        end else if (apply_desc) begin
            unit <= desc_apply(unit, dw);
        end
    end

    p_softreset_r5: assert property (@(posedge clk) disable iff (rst)
        apply_cw && cw[7] |=> unit.cu == CU_IDLE && unit.ru == RU_SUSP && unit.flags == 4'b0000);

    p_abort_r4: assert property (@(posedge clk) disable iff (rst)
        apply_cw && !cw[7] && cw[10:8] == 3'd4 |=> unit.cu == CU_SUSP && unit.flags[1]);

    p_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        !apply_cw && !apply_desc |=> $stable(unit));

endmodule

// File: rtl/seq_ca_pending.sv
module seq_ca_pending #(
    parameter int PEND_W = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic ca,
    input  logic busy,
    input  logic take,
    output logic has_pend
);

    localparam logic [PEND_W-1:0] PEND_MAX = '1;

    logic [PEND_W-1:0] cnt;
    logic              inc;
    logic              dec;

    assign inc      = ca && busy && (cnt != PEND_MAX);
    assign dec      = take && (cnt != '0);
    assign has_pend = (cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (inc && !dec) begin
            cnt <= cnt + 1'b1;
        end else if (dec && !inc) begin
            cnt <= cnt - 1'b1;
        end
    end

    p_take_r10: assert property (@(posedge clk) disable iff (rst)
        take |-> has_pend);

    p_count_r10: assert property (@(posedge clk) disable iff (rst)
        ca && busy && !take && cnt != PEND_MAX |=> cnt == $past(cnt) + 1'b1);

endmodule

// File: rtl/seq_bus_drive.sv
module seq_bus_drive
    import seq_pkg::*;
(
    input  seq_st_e       st,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] ptr,
    input  logic [DW-1:0] stat,
    output logic          req,
    output logic          we,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] wdata
);

    always_comb begin
        req   = 1'b1;
        we    = 1'b0;
        addr  = '0;
        wdata = '0;
        case (st)
            S_CW_RD:    addr = base + CB_COMMAND;
            S_CW_CLR: begin
                we   = 1'b1;
                addr = base + CB_COMMAND;
            end
            S_BASE_LO:  addr = base + CB_LIST_LO;
            S_BASE_HI:  addr = base + CB_LIST_HI;
            S_HDR_WR: begin
                we    = 1'b1;
                addr  = base + CB_STATUS;
                wdata = stat;
            end
            S_D_BUSY: begin
                we    = 1'b1;
                addr  = ptr + DS_STATUS;
                wdata = WORD_BUSY;
            end
            S_D_CMD:    addr = ptr + DS_CMD;
            S_D_DONE: begin
                we    = 1'b1;
                addr  = ptr + DS_STATUS;
                wdata = WORD_DONE;
            end
            S_D_LNK_LO: addr = ptr + DS_LINK_LO;
            S_D_LNK_HI: addr = ptr + DS_LINK_HI;
            default:    req = 1'b0;
        endcase
    end

endmodule

// File: rtl/cmd_chain_seq.sv
module cmd_chain_seq
    import seq_pkg::*;
#(
    parameter int PEND_W = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ca,
    input  logic [31:0] ctrl_base,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [15:0] mem_wdata,
    input  logic        mem_gnt,
    input  logic [15:0] mem_rdata,
    output logic        cmd_valid,
    output logic [2:0]  cmd_opcode,
    output logic [31:0] cmd_addr,
    input  logic        cmd_done,
    output logic        irq
);

    seq_st_e       st;
    logic [DW-1:0] cw_q;
    logic [DW-1:0] dcmd_q;
    logic [DW-1:0] lo_q;
    logic [AW-1:0] ptr_q;
    logic          from_desc;
    unit_t         unit;
    unit_t         cw_next;
    logic          apply_cw;
    logic          apply_desc;
    logic          has_pend;
    logic          take;
    logic          busy;
    logic [AW-1:0] link;

    assign cw_next    = cw_apply(unit, cw_q);
    assign apply_cw   = (st == S_CW_CLR) && mem_gnt;
    assign apply_desc = (st == S_D_LNK_HI) && mem_gnt;
    assign busy       = (st != S_IDLE);
    assign take       = (st == S_IDLE) && !ca && has_pend;
    assign link       = {mem_rdata, lo_q};

    seq_unit_state u_state (
        .clk        (clk),
        .rst        (rst),
        .apply_cw   (apply_cw),
        .cw         (cw_q),
        .apply_desc (apply_desc),
        .dw         (dcmd_q),
        .unit       (unit)
    );

    seq_ca_pending #(.PEND_W(PEND_W)) u_pend (
        .clk      (clk),
        .rst      (rst),
        .ca       (ca),
        .busy     (busy),
        .take     (take),
        .has_pend (has_pend)
    );

    seq_bus_drive u_bus (
        .st    (st),
        .base  (ctrl_base),
        .ptr   (ptr_q),
        .stat  (status_word(unit)),
        .req   (mem_req),
        .we    (mem_we),
        .addr  (mem_addr),
        .wdata (mem_wdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= S_IDLE;
            cw_q      <= '0;
            dcmd_q    <= '0;
            lo_q      <= '0;
            ptr_q     <= PTR_NULL;
            from_desc <= 1'b0;
        end else begin
            case (st)
                S_IDLE: if (ca || has_pend) st <= S_CW_RD;
                S_CW_RD: if (mem_gnt) begin
                    cw_q <= mem_rdata;
                    st   <= S_CW_CLR;
                end
                S_CW_CLR: if (mem_gnt) begin
                    from_desc <= 1'b0;
                    if (cw_q[7]) ptr_q <= PTR_NULL;
                    if (cw_next.cu != CU_SUSP && (cw_q[7] || ptr_q == PTR_NULL))
                        st <= S_BASE_LO;
                    else
                        st <= S_HDR_WR;
                end
                S_BASE_LO: if (mem_gnt) begin
                    lo_q <= mem_rdata;
                    st   <= S_BASE_HI;
                end
                S_BASE_HI: if (mem_gnt) begin
                    ptr_q <= link;
                    st    <= S_HDR_WR;
                end
                S_HDR_WR: if (mem_gnt) begin
                    st <= (unit.cu == CU_ACT && ptr_q != PTR_NULL) ? S_D_BUSY : S_IDLE;
                end
                S_D_BUSY: if (mem_gnt) st <= S_D_CMD;
                S_D_CMD: if (mem_gnt) begin
                    dcmd_q <= mem_rdata;
                    st     <= S_D_EXEC;
                end
                S_D_EXEC: if (cmd_done) st <= S_D_DONE;
                S_D_DONE: if (mem_gnt) st <= S_D_LNK_LO;
                S_D_LNK_LO: if (mem_gnt) begin
                    lo_q <= mem_rdata;
                    st   <= S_D_LNK_HI;
                end
                S_D_LNK_HI: if (mem_gnt) begin
                    ptr_q     <= (dcmd_q[15] || link == '0) ? PTR_NULL : link;
                    from_desc <= 1'b1;
                    st        <= S_HDR_WR;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    assign cmd_valid  = (st == S_D_EXEC);
    assign cmd_opcode = dcmd_q[2:0];
    assign cmd_addr   = ptr_q;
    assign irq        = (st == S_HDR_WR) && from_desc && dcmd_q[13];

    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

    p_disp_hold_r11: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && !cmd_done |=> cmd_valid && $stable(cmd_addr) && $stable(cmd_opcode));

    p_irq_r9: assert property (@(posedge clk) disable iff (rst)
        irq |-> mem_req && mem_we && mem_addr == ctrl_base);

    p_walk_active_r7: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> unit.cu == CU_ACT && cmd_addr != PTR_NULL);

endmodule

// File: tb/cmd_chain_seq_test.sv
module cmd_chain_seq_test;

    localparam int BASE = 'h100;
    localparam logic [31:0] NUL = 32'hFFFF_FFFF;

    typedef struct {
        bit    we;
        int    addr;
        int    data;
        bit    irq;
        string tag;
    } txn_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ca  = 1'b0;
    logic        mem_req, mem_we, mem_gnt;
    logic [31:0] mem_addr;
    logic [15:0] mem_wdata, mem_rdata;
    logic        cmd_valid, cmd_done, irq;
    logic [2:0]  cmd_opcode;
    logic [31:0] cmd_addr;
    logic        gate = 1'b0;

    logic [15:0] mem [256];
    int          rm  [256];

    txn_t q[$];
    int   dq_op[$];
    int   dq_addr[$];

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int ex_cnt = 0;

    int          m_flags, m_cu, m_ru;
    logic [31:0] m_ptr;

    bit          hold_wait = 0;
    logic [31:0] h_addr;
    logic        h_we;
    logic [15:0] h_wd;

    always #5 clk = ~clk;

    assign mem_gnt   = mem_req && gate;
    assign mem_rdata = mem[mem_addr[8:1]];

    cmd_chain_seq uut (
        .clk        (clk),
        .rst        (rst),
        .ca         (ca),
        .ctrl_base  (32'(BASE)),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_gnt    (mem_gnt),
        .mem_rdata  (mem_rdata),
        .cmd_valid  (cmd_valid),
        .cmd_opcode (cmd_opcode),
        .cmd_addr   (cmd_addr),
        .cmd_done   (cmd_done),
        .irq        (irq)
    );

    task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // grant pattern and executor, driven after the edge
    initial cmd_done = 1'b0;
    always @(posedge clk) begin
        cyc++;
        #1;
        gate = (cyc % 4) != 2;
        if (cmd_done) cmd_done = 1'b0;
        else if (cmd_valid) begin
            if (ex_cnt == 2) begin
                cmd_done = 1'b1;
                ex_cnt = 0;
            end else ex_cnt++;
        end
    end

    // comparison on every clock, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            if (hold_wait)
                check(mem_req && mem_addr == h_addr && mem_we == h_we && mem_wdata == h_wd,
                      "R11", "held request", int'(mem_addr), int'(h_addr));
            hold_wait = mem_req && !mem_gnt;
            h_addr = mem_addr; h_we = mem_we; h_wd = mem_wdata;

            if (mem_req) begin
                if (q.size() == 0)
                    check(0, "R2", "unexpected request addr", int'(mem_addr), -1);
                else
                    check(irq == q[0].irq, "R9", "irq level", int'(irq), int'(q[0].irq));
            end else if (irq) begin
                check(0, "R9", "irq without status write", 1, 0);
            end

            if (mem_req && mem_gnt && q.size() != 0) begin
                txn_t t;
                t = q.pop_front();
                check(mem_we == t.we && int'(mem_addr) == t.addr, t.tag, "access addr/dir",
                      int'(mem_addr), t.addr);
                if (t.we) begin
                    check(int'(mem_wdata) == t.data, t.tag, "write data", int'(mem_wdata), t.data);
                end
            end
            if (mem_req && mem_gnt && mem_we) mem[mem_addr[8:1]] = mem_wdata;

            if (cmd_valid && cmd_done) begin
                if (dq_op.size() == 0) check(0, "R7", "unexpected dispatch", int'(cmd_addr), -1);
                else begin
                    int eo, ea;
                    eo = dq_op.pop_front();
                    ea = dq_addr.pop_front();
                    check(int'(cmd_opcode) == eo, "R7", "opcode", int'(cmd_opcode), eo);
                    check(int'(cmd_addr) == ea, "R7", "descriptor addr", int'(cmd_addr), ea);
                end
            end
        end
    end

    task automatic wr(input int a, input int v);
        mem[(a >> 1) & 255] = 16'(v);
        rm[(a >> 1) & 255]  = v & 'hFFFF;
    endtask

    task automatic push(input bit we, input int a, input int d, input bit ir, input string tg);
        txn_t t;
        t.we = we; t.addr = a; t.data = d; t.irq = ir; t.tag = tg;
        q.push_back(t);
    endtask

    function automatic int sw();
        return (m_flags << 12) | (m_cu << 8) | (m_ru << 4);
    endfunction

    // behavioural model of one attention pass
    task automatic run_pass(input string tg);
        int cw, cuc, ruc, d, lo, hi, a;
        logic [31:0] nx;
        cw = rm[((BASE + 2) >> 1) & 255];
        push(0, BASE + 2, cw, 0, "R2");
        push(1, BASE + 2, 0, 0, "R2");
        rm[((BASE + 2) >> 1) & 255] = 0;
        m_flags = m_flags & ~((cw >> 12) & 15);
        cuc = (cw >> 8) & 7;
        ruc = (cw >> 4) & 7;
        if (cuc == 1) m_cu = 2;
        else if (cuc == 4) begin m_cu = 1; m_flags |= 2; end
        if (ruc == 1 || ruc == 2) m_ru = 0;
        else if (ruc == 3 || ruc == 4) begin m_ru = 1; m_flags |= 1; end
        if ((cw & 'h80) != 0) begin m_flags = 0; m_cu = 0; m_ru = 1; m_ptr = NUL; end
        if (m_cu != 1 && m_ptr == NUL) begin
            lo = rm[((BASE + 4) >> 1) & 255];
            hi = rm[((BASE + 6) >> 1) & 255];
            push(0, BASE + 4, lo, 0, "R6");
            push(0, BASE + 6, hi, 0, "R6");
            m_ptr = {hi[15:0], lo[15:0]};
        end
        push(1, BASE, sw(), 0, tg);
        while (m_cu == 2 && m_ptr != NUL) begin
            a = int'(m_ptr);
            push(1, a, 'h4000, 0, "R7");
            d = rm[((a + 2) >> 1) & 255];
            push(0, a + 2, d, 0, "R7");
            dq_op.push_back(d & 7);
            dq_addr.push_back(a);
            push(1, a, 'hA000, 0, "R7");
            rm[(a >> 1) & 255] = 'hA000;
            lo = rm[((a + 4) >> 1) & 255];
            hi = rm[((a + 6) >> 1) & 255];
            push(0, a + 4, lo, 0, "R8");
            push(0, a + 6, hi, 0, "R8");
            nx = {hi[15:0], lo[15:0]};
            if (nx == 0 || (d & 'h8000) != 0) nx = NUL;
            if ((d & 'h4000) != 0) m_cu = 1;
            if ((d & 'h2000) != 0) m_flags |= 8; else m_flags &= 7;
            m_ptr = nx;
            push(1, BASE, sw(), (d & 'h2000) != 0, ((d & 'h2000) != 0) ? "R9" : "R8");
        end
    endtask

    task automatic pulse_ca();
        @(posedge clk); #1 ca = 1'b1;
        @(posedge clk); #1 ca = 1'b0;
    endtask

    task automatic wait_quiet(input string tg);
        int quiet = 0;
        int t = 0;
        while (quiet < 4 && t < 3000) begin
            @(negedge clk);
            t++;
            if (q.size() == 0 && dq_op.size() == 0 && !mem_req && !cmd_valid) quiet++;
            else quiet = 0;
        end
        check(q.size() == 0 && dq_op.size() == 0, tg, "outstanding transactions", q.size(), 0);
        q.delete(); dq_op.delete(); dq_addr.delete();
    endtask

    task automatic scenario(input int cw, input string tg);
        wr(BASE + 2, cw);
        run_pass(tg);
        pulse_ca();
        wait_quiet(tg);
    endtask

    initial begin
        for (int i = 0; i < 10000; i++) @(posedge clk);
        check(0, "R1", "watchdog expired", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) begin mem[i] = 16'h0; rm[i] = 0; end
        m_flags = 0; m_cu = 0; m_ru = 1; m_ptr = NUL;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        repeat (4) begin
            @(negedge clk);
            check(!mem_req && !cmd_valid && !irq, "R1", "idle after reset",
                  {mem_req, cmd_valid, irq}, 0);
        end

        // list of three, last one ends the list and interrupts
        wr('h20 + 2, 'h0001); wr('h20 + 4, 'h0040); wr('h20 + 6, 0);
        wr('h40 + 2, 'h0002); wr('h40 + 4, 'h0060); wr('h40 + 6, 0);
        wr('h60 + 2, 'hA004); wr('h60 + 4, 'h0080); wr('h60 + 6, 0);
        wr(BASE + 4, 'h20); wr(BASE + 6, 0);
        scenario('h0110, "R4");

        // acknowledge bit 15, suspend after first descriptor
        wr('h80 + 2, 'h4003); wr('h80 + 4, 'h00A0); wr('h80 + 6, 0);
        wr('hA0 + 2, 'h8000); wr('hA0 + 4, 'h0000); wr('hA0 + 6, 0);
        wr(BASE + 4, 'h80);
        scenario('h8000, "R3");

        // suspended: no reload, no walk; then start resumes at saved pointer
        scenario('h0000, "R6");
        scenario('h0100, "R6");

        // zero link ends the list, interrupt
        wr('hC0 + 2, 'h2005); wr('hC0 + 4, 0); wr('hC0 + 6, 0);
        wr(BASE + 4, 'hC0);
        scenario('h0000, "R8");

        // abort both units, then acknowledge and restart receive
        scenario('h0430, "R4");
        scenario('h3020, "R3");

        // soft reset after fields
        scenario('h0180, "R5");

        // pending attention pulses during a walk
        wr(BASE + 4, 'h20);
        wr('h20 + 2, 'h0001); wr('h40 + 2, 'h0002); wr('h60 + 2, 'hA004);
        wr(BASE + 2, 'h0110);
        run_pass("R10");
        run_pass("R10");
        run_pass("R10");
        pulse_ca();
        repeat (8) @(posedge clk);
        pulse_ca();
        repeat (5) @(posedge clk);
        pulse_ca();
        wait_quiet("R10");

        // descriptor without interrupt clears flag bit 15
        wr('hE0 + 2, 'h8007); wr('hE0 + 4, 'h0000); wr('hE0 + 6, 0);
        wr(BASE + 4, 'hE0);
        scenario('h0000, "R9");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule